// File: doc/BRIEF.md
# Ganged Strobed Input Latch Port

This block takes parallel data from an outside peripheral under a strobe-and-full-flag handshake. The peripheral places bytes on a bus and pulls a shared active-low strobe. The block synchronizes the strobe into its clock domain and detects its falling edge. On that edge every byte lane copies its slice of the bus into a holding register and raises its full flag.

A host reads the lanes one at a time through a select-and-pulse read interface. Each read returns the held byte and empties that lane. Several lanes can be ganged into one wider transfer. They all capture on the same strobe edge, and only the last lane's full flag goes back to the peripheral. The peripheral therefore waits until the host has drained the final lane before it strobes again.

A strobe edge that finds a lane still full does not disturb that lane's held byte. Instead it sets a sticky overrun bit for the lane, which the host can observe.

Top module: `stb_input_gang`

## Requirements
- R1: Each lane is 8 bits wide (LANE_W=8). Lane j takes its byte from `per_data[8j+7:8j]`, and NUM_LANES lanes are present.
- R2: A capture happens only on a falling edge of `per_stb_n` after that edge has passed through two synchronizer flops. Driving the strobe low just after a clock edge sets `lane_full` on the third following rising edge, and not before it.
- R3: All lanes that are empty capture on the same strobe edge. Changes on `per_data` after a capture leave the held bytes unchanged.
- R4: A strobe held low produces exactly one capture. A lane emptied while the strobe stays low is not refilled until the strobe has gone high and then low again.
- R5: A cycle with `host_rd`=1 and `host_sel`=j (j < NUM_LANES) loads lane j's held byte into `host_rdata` at the next rising edge. At that same edge it clears `lane_full[j]` and leaves the other lanes' flags unchanged.
- R6: `per_full` equals the full flag of the last lane, index NUM_LANES-1.
- R7: A strobe edge that finds a lane full leaves that lane's byte unchanged and sets its `lane_ovr` bit. The bit stays set until reset. If a read of that lane falls on the same edge, the edge still counts as an overrun and the read still empties the lane.
- R8: A read with `host_sel` >= NUM_LANES loads 0 into `host_rdata` and changes no full flag.
- R9: A synchronous active-low reset clears all held bytes, full flags, overrun bits and `host_rdata`. It leaves the synchronizer idle-high, so a strobe that is high after reset causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| per_data | input | NUM_LANES*LANE_W | Peripheral data bus, lane j in bits 8j+7..8j |
| per_stb_n | input | 1 | Shared active-low strobe from the peripheral, asynchronous |
| per_full | output | 1 | Full flag of the last lane, returned to the peripheral |
| host_rd | input | 1 | Host read pulse, one cycle per read |
| host_sel | input | SEL_W | Lane index for the read |
| host_rdata | output | LANE_W | Byte returned by the most recent read |
| lane_full | output | NUM_LANES | Full flag of each lane |
| lane_ovr | output | NUM_LANES | Sticky overrun bit of each lane |

## Verification
The bench builds the block with three lanes. This gives a first, a middle and a last lane, which separates the peripheral-facing flag from the others, and leaves one unused select code (3) for the out-of-range read. Every byte value 0 to 255 passes through each lane, with a distinct arithmetic pattern per lane, and the bus is inverted after each capture to show that the held bytes do not follow it. Directed runs then cover a held-low strobe, overruns on full lanes, a read on the same edge as an overrun, and a reset taken while lanes are full.

// File: rtl/stb_gang_pkg.sv
// Package: shared helpers for the ganged strobed input port.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package stb_gang_pkg;

    // Width of a lane index; at least one bit even for a single lane.
    function automatic int sel_width(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

    // Synchronizer depth used by default for the peripheral strobe.
    localparam int DEFAULT_SYNC_STAGES = 2;

endpackage

// File: rtl/stb_sync_fall.sv
// Module: stb_sync_fall
// Brings the asynchronous active-low strobe into the clock domain through
// STAGES flops and emits a one-cycle pulse on each synchronized falling edge.
// Assumes: the strobe idles high; reset loads the chain high so that no
// false edge appears when reset is released.
module stb_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_n_async,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw strobe through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], stb_n_async};
        end
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b1;
        end else begin
            last_q <= chain_q[STAGES-1];
        end
    end

    // A high-to-low change of the synchronized level is a falling edge.
    always_comb begin
        fall = last_q & ~chain_q[STAGES-1];
    end

endmodule

// File: rtl/stb_lane.sv
// Module: stb_lane
// One byte lane: holds the captured byte, its full flag and a sticky
// overrun bit.
// Assumes: fall is a single-cycle pulse, and rd_hit is high for a single
// cycle for each host read that selects this lane.
module stb_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall,
    input  logic         rd_hit,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         full,
    output logic         ovr
);

    logic         take;
    logic         clash;
    logic         full_nx;

    // Decide whether this edge captures or collides with a held byte.
    always_comb begin
        take  = fall & ~full;
        clash = fall &  full;
    end

    // Next full flag: a read empties the lane, a capture fills it.
    always_comb begin
        full_nx = full;
        if (rd_hit) begin
            full_nx = 1'b0;
        end
        if (take) begin
            full_nx = 1'b1;
        end
    end

    // Holding register: loads only on a capture into an empty lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (take) begin
            q <= din;
        end
    end

    // Full flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else begin
            full <= full_nx;
        end
    end

    // Sticky overrun bit, set by a strobe edge that finds the lane full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (clash) begin
            ovr <= 1'b1;
        end
    end

endmodule

// File: rtl/stb_host_read.sv
// Module: stb_host_read
// Host-side read path: decodes the lane select into per-lane read hits and
// registers the selected byte into the read data output.
// Assumes: host_rd is a one-cycle pulse, and selects at or above N are
// treated as empty reads that return zero.
module stb_host_read #(
    parameter int N     = 2,
    parameter int W     = 8,
    parameter int SEL_W = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_rd,
    input  logic [SEL_W-1:0] host_sel,
    input  logic [N*W-1:0] lane_q,
    output logic [N-1:0]   rd_hit,
    output logic [W-1:0]   rdata
);

    logic [W-1:0] pick;

    // Decode select into a one-hot read hit per lane (zero when invalid).
    always_comb begin
        for (int j = 0; j < N; j++) begin
            rd_hit[j] = host_rd && (host_sel == SEL_W'(j));
        end
    end

    // Multiplex the selected lane's byte; zero when the select is invalid.
    always_comb begin
        pick = '0;
        for (int j = 0; j < N; j++) begin
            if (host_sel == SEL_W'(j)) begin
                pick = lane_q[j*W +: W];
            end
        end
    end

    // Register the read data on each host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (host_rd) begin
            rdata <= pick;
        end
    end

endmodule

// File: rtl/stb_input_gang.sv
// Module: stb_input_gang (top)
// Ganged strobed input port: NUM_LANES byte lanes capture a shared peripheral
// bus on one synchronized strobe edge; the host drains them one at a time,
// and the last lane's full flag paces the peripheral.
// Assumes: the peripheral keeps per_data stable from strobe fall until the
// capture edge (SYNC_STAGES+1 clocks), and strobes again only after per_full
// has dropped.
module stb_input_gang
    import stb_gang_pkg::*;
#(
    parameter int NUM_LANES   = 2,
    parameter int LANE_W      = 8,
    parameter int SYNC_STAGES = DEFAULT_SYNC_STAGES,
    parameter int SEL_W       = sel_width(NUM_LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES*LANE_W-1:0] per_data,
    input  logic                        per_stb_n,
    output logic                        per_full,
    input  logic                        host_rd,
    input  logic [SEL_W-1:0]            host_sel,
    output logic [LANE_W-1:0]           host_rdata,
    output logic [NUM_LANES-1:0]        lane_full,
    output logic [NUM_LANES-1:0]        lane_ovr
);

    localparam int BUS_W = NUM_LANES * LANE_W;

    logic                 stb_fall;
    logic [NUM_LANES-1:0] rd_hit;
    logic [BUS_W-1:0]     lane_q;

    stb_sync_fall #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_n_async (per_stb_n),
        .fall        (stb_fall)
    );

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        stb_lane #(
            .W (LANE_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .fall   (stb_fall),
            .rd_hit (rd_hit[j]),
            .din    (per_data[j*LANE_W +: LANE_W]),
            .q      (lane_q[j*LANE_W +: LANE_W]),
            .full   (lane_full[j]),
            .ovr    (lane_ovr[j])
        );
    end

    stb_host_read #(
        .N     (NUM_LANES),
        .W     (LANE_W),
        .SEL_W (SEL_W)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_rd  (host_rd),
        .host_sel (host_sel),
        .lane_q   (lane_q),
        .rd_hit   (rd_hit),
        .rdata    (host_rdata)
    );

    // Return only the last lane's full flag to the peripheral.
    always_comb begin
        per_full = lane_full[NUM_LANES-1];
    end

endmodule

// File: rtl/stb_input_gang_chk.sv
// Module: stb_input_gang_chk
// Property checker for stb_input_gang, attached by the bind at the end of
// this file.
// Assumes: it observes the top's ports and internal strobe-edge and lane
// buses; it drives nothing.
module stb_input_gang_chk #(
    parameter int NUM_LANES = 2,
    parameter int LANE_W    = 8,
    parameter int SEL_W     = 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        stb_fall,
    input logic                        host_rd,
    input logic [SEL_W-1:0]            host_sel,
    input logic [NUM_LANES-1:0]        lane_full,
    input logic [NUM_LANES-1:0]        lane_ovr,
    input logic [NUM_LANES*LANE_W-1:0] lane_q
);

    // R4: an edge pulse never lasts two cycles.
    a_r4_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        stb_fall |=> !stb_fall);

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_chk
        // R2: a lane becomes full only in the cycle after a strobe edge.
        a_r2_fill_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_full[j]) |-> $past(stb_fall));

        // R5: reading a full lane empties it at the next edge.
        a_r5_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (host_rd && host_sel == SEL_W'(j) && lane_full[j]) |=> !lane_full[j]);

        // R7: a full lane keeps its byte.
        a_r7_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            lane_full[j] |=> $stable(lane_q[j*LANE_W +: LANE_W]));

        // R7: overrun stays set once raised.
        a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            lane_ovr[j] |=> lane_ovr[j]);

        // R7: overrun is raised only by an edge that found the lane full.
        a_r7_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_ovr[j]) |-> $past(stb_fall && lane_full[j]));
    end

endmodule

bind stb_input_gang stb_input_gang_chk #(
    .NUM_LANES (NUM_LANES),
    .LANE_W    (LANE_W),
    .SEL_W     (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_fall  (stb_fall),
    .host_rd   (host_rd),
    .host_sel  (host_sel),
    .lane_full (lane_full),
    .lane_ovr  (lane_ovr),
    .lane_q    (lane_q)
);

// File: tb/tb_stb_input_gang.sv
module tb_stb_input_gang;

    localparam int NL = 3;
    localparam int LW = 8;
    localparam int SW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL*LW-1:0] per_data = '0;
    logic            per_stb_n = 1'b1;
    logic            per_full;
    logic            host_rd = 1'b0;
    logic [SW-1:0]   host_sel = '0;
    logic [LW-1:0]   host_rdata;
    logic [NL-1:0]   lane_full;
    logic [NL-1:0]   lane_ovr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    stb_input_gang #(
        .NUM_LANES (NL),
        .LANE_W    (LW)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_data   (per_data),
        .per_stb_n  (per_stb_n),
        .per_full   (per_full),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_rdata (host_rdata),
        .lane_full  (lane_full),
        .lane_ovr   (lane_ovr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-lane byte pattern for sweep index i.
    function automatic logic [LW-1:0] pat(input int i, input int j);
        case (j)
            0:       return LW'(i);
            1:       return LW'(i) ^ 8'hA5;
            default: return LW'((i * 7 + 3) & 255);
        endcase
    endfunction

    function automatic logic [NL*LW-1:0] bus_of(input int i);
        logic [NL*LW-1:0] b;
        for (int j = 0; j < NL; j++) b[j*LW +: LW] = pat(i, j);
        return b;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input int j);
        host_rd = 1'b1;
        host_sel = SW'(j);
        step(1);
        host_rd = 1'b0;
    endtask

    initial begin
        step(2);
        // R9: reset state.
        check("R9 full after reset", 32'(lane_full), 0);
        check("R9 ovr after reset", 32'(lane_ovr), 0);
        check("R9 rdata after reset", 32'(host_rdata), 0);
        check("R6 per_full after reset", 32'(per_full), 0);
        rst_n = 1'b1;
        step(4);
        check("R9 idle strobe no capture", 32'(lane_full), 0);

        // R1 R2 R3 R5 R6: sweep every byte value through every lane.
        for (int i = 0; i < 256; i++) begin
            per_data = bus_of(i);
            per_stb_n = 1'b0;
            step(2);
            check("R2 not full before third edge", 32'(lane_full), 0);
            step(1);
            check("R2 R3 all lanes full on third edge", 32'(lane_full), 7);
            per_data = ~bus_of(i);
            per_stb_n = 1'b1;
            step(3);
            for (int j = 0; j < NL; j++) begin
                do_read(j);
                check("R1 R3 R5 read byte", 32'(host_rdata), 32'(pat(i, j)));
                check("R5 full after read", 32'(lane_full), 32'((7 << (j + 1)) & 7));
                check("R6 per_full", 32'(per_full), (j == NL - 1) ? 0 : 1);
            end
        end
        check("R7 no overrun in paced sweep", 32'(lane_ovr), 0);

        // R4: held-low strobe captures once.
        per_data = bus_of(10);
        per_stb_n = 1'b0;
        step(3);
        for (int j = 0; j < NL; j++) do_read(j);
        step(5);
        check("R4 no refill while strobe low", 32'(lane_full), 0);
        per_stb_n = 1'b1;
        step(3);
        check("R4 rise alone no capture", 32'(lane_full), 0);

        // R7: overrun on full lanes.
        per_data = bus_of(20);
        per_stb_n = 1'b0;
        step(3);
        per_stb_n = 1'b1;
        step(3);
        per_data = bus_of(30);
        per_stb_n = 1'b0;
        step(3);
        check("R7 ovr set on all full lanes", 32'(lane_ovr), 7);
        check("R7 full unchanged", 32'(lane_full), 7);
        per_stb_n = 1'b1;
        step(3);
        for (int j = 0; j < NL; j++) begin
            do_read(j);
            check("R7 byte kept through overrun", 32'(host_rdata), 32'(pat(20, j)));
        end
        check("R7 ovr sticky after reads", 32'(lane_ovr), 7);

        // R9: reset clears ovr, full, bytes, rdata.
        per_stb_n = 1'b0;
        step(3);
        rst_n = 1'b0;
        step(1);
        check("R9 full cleared", 32'(lane_full), 0);
        check("R9 ovr cleared", 32'(lane_ovr), 0);
        check("R9 rdata cleared", 32'(host_rdata), 0);
        per_stb_n = 1'b1;
        step(1);
        rst_n = 1'b1;
        step(3);
        do_read(1);
        check("R9 byte cleared", 32'(host_rdata), 0);

        // R7: read on the same edge as an overrun.
        per_data = bus_of(40);
        per_stb_n = 1'b0;
        step(3);
        per_stb_n = 1'b1;
        step(3);
        do_read(0);
        do_read(1);
        per_data = bus_of(50);
        per_stb_n = 1'b0;
        step(2);
        host_rd = 1'b1;
        host_sel = SW'(2);
        step(1);
        host_rd = 1'b0;
        check("R7 same-edge read empties last lane", 32'(lane_full), 3);
        check("R7 same-edge overrun on last lane", 32'(lane_ovr), 4);
        check("R7 same-edge read byte", 32'(host_rdata), 32'(pat(40, 2)));
        do_read(0);
        check("R3 empty lane refilled", 32'(host_rdata), 32'(pat(50, 0)));
        per_stb_n = 1'b1;
        step(3);

        // R8: out-of-range select.
        do_read(3);
        check("R8 invalid select data", 32'(host_rdata), 0);
        check("R8 invalid select flags", 32'(lane_full), 2);
        do_read(1);
        check("R8 lane intact after invalid read", 32'(host_rdata), 32'(pat(50, 1)));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule